// File: doc/BRIEF.md
# Wide-register read snapshot buffer

This block lets a narrow CPU bus read a hardware status register that is wider than one bus access, and get a coherent value. A capture event copies the whole live register into a snapshot. The CPU then fetches the snapshot one access-width sub-word at a time. Each sub-word has its own decoded read strobe. Every readback slot drives zero while it is not selected, so the slots are ORed onto one data output.

A parameter picks the capture source. The first choice is the register itself, where capture happens on a read of its lowest sub-word. The second is a read of the lowest sub-word of another register. The third is an external signal whose polarity is set by a parameter. When the register is its own trigger, the sub-word 0 read is served from the live fields, and the same clock edge fills the snapshot for the sub-words that follow. Live field values arrive at their field positions. Before they are captured or returned, uncovered bits are zeroed and fields declared with reversed ordering are bit-reversed. A side-effect pulse goes out on each capture, and not on every sub-word access, so that clear-on-read and modified-flag logic outside this block acts once per coherent read.

Top module: `wide_read_snap`

## Requirements
- R1: With the self trigger and the default 64-bit register over a 32-bit access width, a read of sub-word 1 (strobe bit 1, write flag low) returns packed bits 63:32 as they were on the clock edge of the most recent sub-word 0 read. A change of the live fields in between does not affect it.
- R2: With the self trigger, a read of sub-word 0 (strobe bit 0, write flag low) returns packed live bits 31:0 in the same cycle. A field that straddles bit 31 is cut to the bits below 32.
- R3: With the register trigger, capture happens on the clock edge where the trigger strobe input is high and the write flag is low. All sub-words, sub-word 0 included, then return snapshot slices.
- R4: With the external trigger and an active-low polarity, capture happens on every clock edge where the trigger input is low. While it is high, the snapshot is held.
- R5: While the write flag is high, no read strobe captures, the data output is zero, and the side-effect output stays low.
- R6: In the default layout, fields sit at bits 11:0, 35:20 and 59:40. Bits 19:12, 39:36 and 63:60 read as zero whatever the live input holds.
- R7: The default field at bits 35:20 is reversed: packed bit 20+k equals live bit 35-k.
- R8: With no strobe active, the data output is zero. At most one strobe is active at a time.
- R9: The side-effect output is high exactly in the cycles where a capture trigger fires. Reads of sub-words that are not the trigger do not raise it.
- R10: While the active-low reset is asserted, a trigger neither captures nor raises the side-effect output.
- R11: With the self trigger and a register no wider than the access width, every read returns the current live packed value, like an unbuffered register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; capture on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks capture |
| rd_strb_i | input | REG_W/ACC_W (2) | Decoded per-sub-word access strobes |
| req_is_wr_i | input | 1 | High when the current request is a write |
| trig_strb0_i | input | 1 | Sub-word 0 strobe of the triggering register (register trigger) |
| ext_trig_i | input | 1 | External capture signal (external trigger) |
| field_i | input | REG_W | Live field values at their field bit positions |
| rd_data_o | output | BUS_W | ORed readback data |
| rd_effect_o | output | 1 | Read side-effect pulse, high on capture |

## Verification
Under the self trigger, the sub-word 0 read does two things in one cycle: it returns live data through the bypass path, and its clock edge loads the snapshot. The bench drives a live value with the sub-word 0 strobe and samples the output before the edge. It then changes the live value together with the sub-word 1 strobe on the next cycle. Sub-word 0 is judged against the packed first value. Sub-word 1 must also carry the first value and never the second, which shows that capture and bypass both used the same cycle's data.

// File: rtl/wide_read_snap_pkg.sv
package wide_read_snap_pkg;
  typedef enum logic [1:0] {
    TRIG_SELF = 2'd0,
    TRIG_REG  = 2'd1,
    TRIG_EXT  = 2'd2
  } trig_src_e;
endpackage

// File: rtl/wide_read_snap_pack.sv
module wide_read_snap_pack #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned N_FLD = 3,
  parameter int unsigned FLD_LO  [N_FLD] = '{0, 20, 40},
  parameter int unsigned FLD_W   [N_FLD] = '{12, 16, 20},
  parameter bit          FLD_REV [N_FLD] = '{1'b0, 1'b1, 1'b0}
) (
  input  logic [REG_W-1:0] live_i,
  output logic [REG_W-1:0] packed_o
);
  logic [REG_W-1:0] acc [N_FLD+1];
  assign acc[0] = '0;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    logic [REG_W-1:0] part;
    always_comb begin
      part = '0;
      for (int k = 0; k < int'(FLD_W[f]); k++) begin
        if (FLD_REV[f]) part[FLD_LO[f]+k] = live_i[FLD_LO[f]+FLD_W[f]-1-k];
        else            part[FLD_LO[f]+k] = live_i[FLD_LO[f]+k];
      end
    end
    assign acc[f+1] = acc[f] | part;
  end

  assign packed_o = acc[N_FLD];
endmodule

// File: rtl/wide_read_snap_trig.sv
module wide_read_snap_trig
  import wide_read_snap_pkg::*;
#(
  parameter trig_src_e TRIG_SRC     = TRIG_SELF,
  parameter bit        EXT_ACT_HIGH = 1'b1
) (
  input  logic rst_ni,
  input  logic own_strb0_i,
  input  logic req_is_wr_i,
  input  logic trig_strb0_i,
  input  logic ext_trig_i,
  output logic fire_o
);
  logic raw;
  always_comb begin
    unique case (TRIG_SRC)
      TRIG_REG: raw = trig_strb0_i & ~req_is_wr_i;
      TRIG_EXT: raw = EXT_ACT_HIGH ? ext_trig_i : ~ext_trig_i;
      default:  raw = own_strb0_i & ~req_is_wr_i;
    endcase
  end
  assign fire_o = raw & rst_ni;
endmodule

// File: rtl/wide_read_snap_rdmux.sv
module wide_read_snap_rdmux #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned N_SUB  = 2,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned PAD_W = N_SUB * ACC_W
) (
  input  logic [N_SUB-1:0] strb_i,
  input  logic             req_is_wr_i,
  input  logic [PAD_W-1:0] live_i,
  input  logic [PAD_W-1:0] snap_i,
  output logic [BUS_W-1:0] data_o
);
  logic [BUS_W-1:0] acc [N_SUB+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < N_SUB; i++) begin : g_slot
    logic [ACC_W-1:0] src;
    logic [BUS_W-1:0] slot;
    if (BYPASS && i == 0) begin : g_live
      assign src = live_i[ACC_W-1:0];
    end else begin : g_snap
      assign src = snap_i[i*ACC_W +: ACC_W];
    end
    assign slot = (strb_i[i] && !req_is_wr_i) ? BUS_W'(src) : '0;
    assign acc[i+1] = acc[i] | slot;
  end

  assign data_o = acc[N_SUB];
endmodule

// File: rtl/wide_read_snap.sv
module wide_read_snap
  import wide_read_snap_pkg::*;
#(
  parameter int unsigned REG_W = 64,
  parameter int unsigned ACC_W = 32,
  parameter int unsigned BUS_W = 32,
  parameter trig_src_e   TRIG_SRC     = TRIG_SELF,
  parameter bit          EXT_ACT_HIGH = 1'b1,
  parameter int unsigned N_FLD = 3,
  parameter int unsigned FLD_LO  [N_FLD] = '{0, 20, 40},
  parameter int unsigned FLD_W   [N_FLD] = '{12, 16, 20},
  parameter bit          FLD_REV [N_FLD] = '{1'b0, 1'b1, 1'b0}
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [(REG_W+ACC_W-1)/ACC_W-1:0] rd_strb_i,
  input  logic                           req_is_wr_i,
  input  logic                           trig_strb0_i,
  input  logic                           ext_trig_i,
  input  logic [REG_W-1:0]               field_i,
  output logic [BUS_W-1:0]               rd_data_o,
  output logic                           rd_effect_o
);
  localparam int unsigned N_SUB = (REG_W + ACC_W - 1) / ACC_W;
  localparam int unsigned PAD_W = N_SUB * ACC_W;
  localparam bit          SELF  = (TRIG_SRC == TRIG_SELF);

  logic [REG_W-1:0] packed_live;
  logic [PAD_W-1:0] live_pad;
  logic [PAD_W-1:0] snap_q;
  logic             fire;

  wide_read_snap_pack #(
    .REG_W(REG_W), .N_FLD(N_FLD),
    .FLD_LO(FLD_LO), .FLD_W(FLD_W), .FLD_REV(FLD_REV)
  ) i_pack (
    .live_i  (field_i),
    .packed_o(packed_live)
  );

  assign live_pad = PAD_W'(packed_live);

  wide_read_snap_trig #(
    .TRIG_SRC(TRIG_SRC), .EXT_ACT_HIGH(EXT_ACT_HIGH)
  ) i_trig (
    .rst_ni      (rst_ni),
    .own_strb0_i (rd_strb_i[0]),
    .req_is_wr_i (req_is_wr_i),
    .trig_strb0_i(trig_strb0_i),
    .ext_trig_i  (ext_trig_i),
    .fire_o      (fire)
  );

  // snapshot has no reset; capture is gated by reset in the trigger
  always_ff @(posedge clk_i) begin
    if (fire) snap_q <= live_pad;
  end

  wide_read_snap_rdmux #(
    .ACC_W(ACC_W), .BUS_W(BUS_W), .N_SUB(N_SUB), .BYPASS(SELF)
  ) i_rdmux (
    .strb_i     (rd_strb_i),
    .req_is_wr_i(req_is_wr_i),
    .live_i     (live_pad),
    .snap_i     (snap_q),
    .data_o     (rd_data_o)
  );

  assign rd_effect_o = fire;
endmodule

// File: rtl/wide_read_snap_chk.sv
module wide_read_snap_chk
  import wide_read_snap_pkg::*;
#(
  parameter int unsigned N_SUB    = 2,
  parameter int unsigned BUS_W    = 32,
  parameter trig_src_e   TRIG_SRC = TRIG_SELF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SUB-1:0] rd_strb_i,
  input logic             req_is_wr_i,
  input logic             trig_strb0_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             rd_effect_o
);
  // R5, R8: unselected or write request drives zero
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strb_i == '0 || req_is_wr_i) |-> rd_data_o == '0);

  p_onehot_strb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_strb_i));

  p_no_fire_reset_r10: assert property (@(posedge clk_i)
    !rst_ni |-> !rd_effect_o);

  if (TRIG_SRC == TRIG_SELF) begin : g_self
    p_effect_self_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_effect_o == (rd_strb_i[0] && !req_is_wr_i));
  end else if (TRIG_SRC == TRIG_REG) begin : g_reg
    p_effect_reg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_effect_o == (trig_strb0_i && !req_is_wr_i));
  end

  if (N_SUB > 1) begin : g_hold
    logic top_rd;
    assign top_rd = rd_strb_i[N_SUB-1] && !req_is_wr_i;
    p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (top_rd && $past(top_rd) && !$past(rd_effect_o)) |-> $stable(rd_data_o));
  end
endmodule

bind wide_read_snap wide_read_snap_chk #(
  .N_SUB(N_SUB), .BUS_W(BUS_W), .TRIG_SRC(TRIG_SRC)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_strb_i   (rd_strb_i),
  .req_is_wr_i (req_is_wr_i),
  .trig_strb0_i(trig_strb0_i),
  .rd_data_o   (rd_data_o),
  .rd_effect_o (rd_effect_o)
);

// File: tb/test_wide_read_snap.sv
module test_wide_read_snap;
  import wide_read_snap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  strb = '0;
  logic        wr = 1'b0;
  logic        trig = 1'b0;
  logic        ext = 1'b1;
  logic [63:0] fld = '0;
  logic [31:0] nfld = '0;
  logic [31:0] rd_self, rd_reg, rd_ext, rd_nar;
  logic        eff_self, eff_reg, eff_ext, eff_nar;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wide_read_snap i_wide_read_snap (
    .clk_i(clk), .rst_ni(rst_ni), .rd_strb_i(strb), .req_is_wr_i(wr),
    .trig_strb0_i(trig), .ext_trig_i(ext), .field_i(fld),
    .rd_data_o(rd_self), .rd_effect_o(eff_self));

  wide_read_snap #(.TRIG_SRC(TRIG_REG)) i_wide_read_snap_reg (
    .clk_i(clk), .rst_ni(rst_ni), .rd_strb_i(strb), .req_is_wr_i(wr),
    .trig_strb0_i(trig), .ext_trig_i(ext), .field_i(fld),
    .rd_data_o(rd_reg), .rd_effect_o(eff_reg));

  wide_read_snap #(.TRIG_SRC(TRIG_EXT), .EXT_ACT_HIGH(1'b0)) i_wide_read_snap_ext (
    .clk_i(clk), .rst_ni(rst_ni), .rd_strb_i(strb), .req_is_wr_i(wr),
    .trig_strb0_i(trig), .ext_trig_i(ext), .field_i(fld),
    .rd_data_o(rd_ext), .rd_effect_o(eff_ext));

  wide_read_snap #(
    .REG_W(32), .FLD_LO('{0, 8, 16}), .FLD_W('{4, 4, 8}),
    .FLD_REV('{1'b0, 1'b0, 1'b0})
  ) i_wide_read_snap_nar (
    .clk_i(clk), .rst_ni(rst_ni), .rd_strb_i(strb[0]), .req_is_wr_i(wr),
    .trig_strb0_i(trig), .ext_trig_i(ext), .field_i(nfld),
    .rd_data_o(rd_nar), .rd_effect_o(eff_nar));

  // expected packing of the default layout (R6, R7)
  function automatic logic [63:0] mdl(input logic [63:0] v);
    logic [63:0] r = '0;
    r[11:0] = v[11:0];
    for (int k = 0; k < 16; k++) r[20+k] = v[35-k];
    r[59:40] = v[59:40];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns later (before the rising edge)
  task automatic step(input logic [1:0] s, input logic w, input logic t,
                      input logic e, input logic [63:0] v);
    @(negedge clk);
    strb = s; wr = w; trig = t; ext = e; fld = v;
    #2;
  endtask

  localparam logic [63:0] VEC_A [4] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
    64'h0000_0008_0000_0000, 64'hDEAD_BEEF_0BAD_F00D};
  localparam logic [63:0] VEC_B [4] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hA5A5_A5A5_A5A5_A5A5, 64'h1};

  initial begin
    logic [63:0] keep;
    step(2'b00, 0, 0, 1, '0);
    chk("R8 reset idle", rd_self, 0);
    step(2'b01, 0, 1, 1, 64'h1234);
    chk("R10 no effect in reset", eff_reg, 0);
    @(negedge clk); rst_ni = 1'b1;

    // vector table: sub-word 0 live, sub-word 1 from snapshot
    for (int n = 0; n < 4; n++) begin
      step(2'b01, 0, 0, 1, VEC_A[n]);
      chk("R2 sub-word 0 live", rd_self, mdl(VEC_A[n]) & 64'hFFFF_FFFF);
      chk("R9 effect on trigger", eff_self, 1);
      step(2'b10, 0, 0, 1, VEC_B[n]);
      chk("R1 sub-word 1 snapshot", rd_self, mdl(VEC_A[n]) >> 32);
      chk("R9 no effect on sub-word 1", eff_self, 0);
    end
    keep = mdl(VEC_A[3]);

    // R6: gaps stay zero on all-ones input
    step(2'b01, 0, 0, 1, '1);
    chk("R6 sub-word 0 gaps", rd_self, 32'hFFF0_0FFF);
    step(2'b10, 0, 0, 1, '0);
    chk("R6 sub-word 1 gaps", rd_self, 32'h0FFF_FF0F);
    // R7: bit 20 lands at packed bit 35
    step(2'b01, 0, 0, 1, 64'h0010_0000);
    chk("R7 bit 20 out of sub-word 0", rd_self, 0);
    step(2'b10, 0, 0, 1, '0);
    chk("R7 packed bit 35", rd_self, 32'h8);
    keep = mdl(64'h0010_0000);

    // R5: write does not capture or return
    step(2'b01, 1, 0, 1, '1);
    chk("R5 write data zero", rd_self, 0);
    chk("R5 write no effect", eff_self, 0);
    step(2'b10, 0, 0, 1, '0);
    chk("R5 snapshot kept", rd_self, keep >> 32);
    step(2'b00, 0, 0, 1, '1);
    chk("R8 no strobe zero", rd_self | rd_reg | rd_nar, 0);

    // R3: register trigger
    step(2'b00, 0, 1, 1, 64'h0123_4567_89AB_CDEF);
    chk("R3 trigger effect", eff_reg, 1);
    step(2'b01, 0, 0, 1, '1);
    chk("R3 sub-word 0 snapshot", rd_reg, mdl(64'h0123_4567_89AB_CDEF) & 64'hFFFF_FFFF);
    step(2'b10, 0, 0, 1, '0);
    chk("R3 sub-word 1 snapshot", rd_reg, mdl(64'h0123_4567_89AB_CDEF) >> 32);
    step(2'b00, 0, 1, 1, 64'h55);
    step(2'b01, 1, 1, 1, '1);
    chk("R3 write trigger no effect", eff_reg, 0);
    step(2'b01, 0, 0, 1, '0);
    chk("R3 write did not capture", rd_reg, 32'h55);

    // R10: trigger during reset ignored
    @(negedge clk); rst_ni = 1'b0;
    step(2'b00, 0, 1, 1, '1);
    chk("R10 effect low in reset", eff_reg, 0);
    @(negedge clk); rst_ni = 1'b1; trig = 0;
    step(2'b01, 0, 0, 1, '0);
    chk("R10 no capture in reset", rd_reg, 32'h55);

    // R4: active-low external trigger
    step(2'b00, 0, 0, 0, 64'hFFFF_0000_0000_0ABC);
    chk("R4 low level fires", eff_ext, 1);
    step(2'b01, 0, 0, 1, '1);
    chk("R4 high level holds", eff_ext, 0);
    chk("R4 sub-word 0 snapshot", rd_ext, 32'h0ABC);
    step(2'b10, 0, 0, 1, '1);
    chk("R4 sub-word 1 snapshot", rd_ext, 32'h0FFF_0000);

    // R11: narrow self-triggered register is unbuffered
    @(negedge clk); nfld = 32'hFFFF_FFFF; strb = 2'b01; trig = 0; #2;
    chk("R11 narrow live", rd_nar, 32'h00FF_0F0F);
    @(negedge clk); nfld = 32'h0012_0304; #2;
    chk("R11 narrow follows live", rd_nar, 32'h0012_0304);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule